// File: doc/BRIEF.md
# Clock and Reset Status Flag Register

This block is the eight-bit status register of a clock and reset unit. It latches four kinds of event: the end of a periodic timeout interval, a power-on reset, a low-voltage reset, and changes of the PLL lock or self-clock-mode status. It also shows the live PLL lock, PLL track and self-clock-mode levels. Software reads the whole byte at once. It clears any latched event by writing a byte with a 1 in that bit's position. Three interrupt requests are formed from the latched timeout, lock-change and self-clock-change flags, each gated by its own enable input.

The two reset-cause flags live in their own reset domains, so a system reset leaves them intact and software can learn why the chip restarted. The power-on flag is set for as long as `pwr_on_rst` is high. The low-voltage flag is set by a pulse on `lowv_rst_evt` and is cleared by a power-on reset. The live status inputs are registered once. The registered lock and self-clock values are then compared with their previous samples to detect changes in either direction.

Top module: `clkrst_flag_reg`

## Requirements
- R1: `rd_data` has this bit layout, from bit 7 down to bit 0: timeout flag, power-on flag, low-voltage flag, lock-change flag, lock status, track status, self-clock-change flag, self-clock status.
- R2: A one-cycle high on `tmo_pulse` sets bit 7 after the next clock edge. A write (`wr_en` high) with `wr_data[7]`=1 clears it. A write with `wr_data[7]`=0 leaves it unchanged.
- R3: If a flag's set event and a write-1 clear of that flag occur in the same cycle, the flag is 1 after the edge.
- R4: `tmo_irq` equals bit 7 AND `tmo_irq_en`. `lock_irq` equals bit 4 AND `lock_irq_en`. `scm_irq` equals bit 1 AND `scm_irq_en`.
- R5: Bit 6 is 1 after `pwr_on_rst` has been high. It is unchanged by `sys_rst` and is cleared by a write with `wr_data[6]`=1.
- R6: A one-cycle high on `lowv_rst_evt` sets bit 5, which then survives `sys_rst`. A write with `wr_data[5]`=1 clears it, and so does `pwr_on_rst`. When `HAS_LOWV`=0, bit 5 always reads 0.
- R7: Bit 3 shows `pll_lock` one clock edge after the input changes. Bit 4 sets one edge after bit 3 changes value, on a rise or a fall.
- R8: Bit 2 shows `pll_track` one clock edge after the input changes. Writes have no effect on bits 3, 2 and 0.
- R9: Bit 0 shows `self_clk` one edge after the input changes, and bits 3 and 2 read 0 while bit 0 is 1. Bit 1 sets one edge after bit 0 changes value, on a rise or a fall.
- R10: After `sys_rst`, with the status inputs low, bits 7, 4, 3, 2, 1 and 0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| sys_rst | input | 1 | Synchronous active-high system reset |
| pwr_on_rst | input | 1 | Synchronous active-high power-on reset; also resets the system domain |
| lowv_rst_evt | input | 1 | Pulse marking a low-voltage reset |
| tmo_pulse | input | 1 | Pulse at the end of each periodic timeout interval |
| pll_lock | input | 1 | Live PLL lock level |
| pll_track | input | 1 | Live PLL track level |
| self_clk | input | 1 | Live self-clock-mode level |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Write data; a 1 clears the matching flag |
| tmo_irq_en | input | 1 | Timeout interrupt enable |
| lock_irq_en | input | 1 | Lock-change interrupt enable |
| scm_irq_en | input | 1 | Self-clock-change interrupt enable |
| rd_data | output | 8 | Register contents |
| tmo_irq | output | 1 | Timeout interrupt request |
| lock_irq | output | 1 | Lock-change interrupt request |
| scm_irq | output | 1 | Self-clock-change interrupt request |

## Verification
The lock input is driven through both a rising and a falling transition. This separates a detector that works in both directions from one that catches a single edge, and shows whether the change flag trails the status bit by one cycle. Self-clock mode is entered while lock and track are high, which checks that the status bits are gated and that the gating registers as a lock change. Write patterns of all zeros, single ones, all ones, and a clear that lands together with a set event distinguish write-one-to-clear from plain writes and check that the set takes priority. A system reset followed by a power-on reset, with both reset-cause flags set beforehand, shows which domain each flag belongs to.

// File: rtl/clkrst_flag_pkg.sv
package clkrst_flag_pkg;
  localparam int REG_W     = 8;
  localparam int BIT_TMO   = 7;
  localparam int BIT_POR   = 6;
  localparam int BIT_LOWV  = 5;
  localparam int BIT_LKCHG = 4;
  localparam int BIT_LOCK  = 3;
  localparam int BIT_TRACK = 2;
  localparam int BIT_SCCHG = 1;
  localparam int BIT_SCM   = 0;
  localparam int MON_W     = 2;
  localparam int MON_LOCK  = 1;
  localparam int MON_SCM   = 0;
endpackage

// File: rtl/clkrst_w1c_flag.sv
module clkrst_w1c_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);
  // set has priority over a same-cycle clear so no event is dropped
  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= set | (q & ~clr);
  end
endmodule

// File: rtl/clkrst_edge_track.sv
module clkrst_edge_track #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] cur,
  output logic [W-1:0] chg
);
  logic [W-1:0] prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur  <= '0;
      prev <= '0;
    end else begin
      cur  <= din;
      prev <= cur;
    end
  end

  assign chg = cur ^ prev;
endmodule

// File: rtl/clkrst_flag_reg.sv
module clkrst_flag_reg
  import clkrst_flag_pkg::*;
#(
  parameter bit HAS_LOWV = 1'b1
) (
  input  logic             clk,
  input  logic             sys_rst,
  input  logic             pwr_on_rst,
  input  logic             lowv_rst_evt,
  input  logic             tmo_pulse,
  input  logic             pll_lock,
  input  logic             pll_track,
  input  logic             self_clk,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             tmo_irq_en,
  input  logic             lock_irq_en,
  input  logic             scm_irq_en,
  output logic [REG_W-1:0] rd_data,
  output logic             tmo_irq,
  output logic             lock_irq,
  output logic             scm_irq
);
  logic             dom_rst;
  logic [REG_W-1:0] clr_vec;
  logic [MON_W-1:0] mon_in, mon_cur, mon_chg;
  logic             track_q;
  logic             tmo_f, por_f, lowv_f, lkchg_f, scchg_f;

  assign dom_rst = sys_rst | pwr_on_rst;
  assign clr_vec = wr_en ? wr_data : '0;

  // status gated before registering, so that entering self-clock mode registers as a lock change
  assign mon_in[MON_LOCK] = pll_lock & ~self_clk;
  assign mon_in[MON_SCM]  = self_clk;

  clkrst_edge_track #(.W(MON_W)) mon_i (
    .clk(clk), .rst(dom_rst), .din(mon_in), .cur(mon_cur), .chg(mon_chg)
  );

  always_ff @(posedge clk) begin
    if (dom_rst) track_q <= 1'b0;
    else         track_q <= pll_track & ~self_clk;
  end

  clkrst_w1c_flag tmo_i (
    .clk(clk), .rst(dom_rst), .set(tmo_pulse), .clr(clr_vec[BIT_TMO]), .q(tmo_f)
  );
  clkrst_w1c_flag lkchg_i (
    .clk(clk), .rst(dom_rst), .set(mon_chg[MON_LOCK]), .clr(clr_vec[BIT_LKCHG]), .q(lkchg_f)
  );
  clkrst_w1c_flag scchg_i (
    .clk(clk), .rst(dom_rst), .set(mon_chg[MON_SCM]), .clr(clr_vec[BIT_SCCHG]), .q(scchg_f)
  );
  // power-on flag: no reset, its own event sets it
  clkrst_w1c_flag por_i (
    .clk(clk), .rst(1'b0), .set(pwr_on_rst), .clr(clr_vec[BIT_POR]), .q(por_f)
  );

  generate
    if (HAS_LOWV) begin : g_lowv
      clkrst_w1c_flag lowv_i (
        .clk(clk), .rst(pwr_on_rst), .set(lowv_rst_evt), .clr(clr_vec[BIT_LOWV]), .q(lowv_f)
      );
    end else begin : g_no_lowv
      logic unused_lowv;
      assign unused_lowv = lowv_rst_evt;
      assign lowv_f = 1'b0;
    end
  endgenerate

  always_comb begin
    rd_data            = '0;
    rd_data[BIT_TMO]   = tmo_f;
    rd_data[BIT_POR]   = por_f;
    rd_data[BIT_LOWV]  = lowv_f;
    rd_data[BIT_LKCHG] = lkchg_f;
    rd_data[BIT_LOCK]  = mon_cur[MON_LOCK];
    rd_data[BIT_TRACK] = track_q;
    rd_data[BIT_SCCHG] = scchg_f;
    rd_data[BIT_SCM]   = mon_cur[MON_SCM];
  end

  assign tmo_irq  = tmo_f   & tmo_irq_en;
  assign lock_irq = lkchg_f & lock_irq_en;
  assign scm_irq  = scchg_f & scm_irq_en;

  // R2: an uncontested write-1 clears the timeout flag
  a_r2_clear: assert property (@(posedge clk) disable iff (dom_rst)
    (wr_en && wr_data[BIT_TMO] && !tmo_pulse) |=> !rd_data[BIT_TMO]);
  // R3: a set event wins even with a clear present
  a_r3_set_wins: assert property (@(posedge clk) disable iff (dom_rst)
    tmo_pulse |=> rd_data[BIT_TMO]);
  // R7: any change in the lock bit raises the change flag next cycle
  a_r7_lock_edge: assert property (@(posedge clk) disable iff (dom_rst)
    (rd_data[BIT_LOCK] != $past(rd_data[BIT_LOCK])) |=> rd_data[BIT_LKCHG]);
  // R9: lock and track are gated off in self-clock mode
  a_r9_scm_gate: assert property (@(posedge clk) disable iff (dom_rst)
    rd_data[BIT_SCM] |-> (!rd_data[BIT_LOCK] && !rd_data[BIT_TRACK]));
  // R5: power-on flag holds unless cleared by software
  a_r5_por_hold: assert property (@(posedge clk) disable iff (pwr_on_rst)
    (rd_data[BIT_POR] && !(wr_en && wr_data[BIT_POR])) |=> rd_data[BIT_POR]);
endmodule

// File: tb/clkrst_flag_reg_tb_top.sv
module clkrst_flag_reg_tb_top;
  logic       clk = 1'b0;
  logic       sys_rst = 1'b0, pwr_on_rst = 1'b1;
  logic       lowv_rst_evt = 1'b0, tmo_pulse = 1'b0;
  logic       pll_lock = 1'b0, pll_track = 1'b0, self_clk = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       tmo_irq_en = 1'b0, lock_irq_en = 1'b0, scm_irq_en = 1'b0;
  logic [7:0] rd_data;
  logic       tmo_irq, lock_irq, scm_irq;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  clkrst_flag_reg dut_i (
    .clk(clk), .sys_rst(sys_rst), .pwr_on_rst(pwr_on_rst), .lowv_rst_evt(lowv_rst_evt),
    .tmo_pulse(tmo_pulse), .pll_lock(pll_lock), .pll_track(pll_track), .self_clk(self_clk),
    .wr_en(wr_en), .wr_data(wr_data), .tmo_irq_en(tmo_irq_en), .lock_irq_en(lock_irq_en),
    .scm_irq_en(scm_irq_en), .rd_data(rd_data), .tmo_irq(tmo_irq), .lock_irq(lock_irq),
    .scm_irq(scm_irq)
  );

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    step();
    wr_en = 1'b0; wr_data = 8'h00;
  endtask

  task automatic t_reset();
    step(); step();
    pwr_on_rst = 1'b0;
    step();
    chk("R10 reset state", rd_data, 8'h40);
    chk("R5 por flag after power-on", {7'd0, rd_data[6]}, 8'h01);
  endtask

  task automatic t_timeout();
    wr(8'hFF);
    tmo_pulse = 1'b1; step(); tmo_pulse = 1'b0;
    chk("R2 timeout sets", rd_data, 8'h80);
    chk("R4 irq masked", {7'd0, tmo_irq}, 8'h00);
    tmo_irq_en = 1'b1; #1;
    chk("R4 irq enabled", {7'd0, tmo_irq}, 8'h01);
    wr(8'h00);
    chk("R2 write 0 keeps", rd_data, 8'h80);
    wr(8'h7F);
    chk("R2 other bits keep", rd_data, 8'h80);
    wr(8'h80);
    chk("R2 write 1 clears", rd_data, 8'h00);
    chk("R4 irq drops", {7'd0, tmo_irq}, 8'h00);
    tmo_irq_en = 1'b0;
  endtask

  task automatic t_set_wins();
    tmo_pulse = 1'b1; wr(8'h80); tmo_pulse = 1'b0;
    chk("R3 set wins over clear", rd_data, 8'h80);
    wr(8'h80);
  endtask

  task automatic t_lock();
    pll_lock = 1'b1; step();
    chk("R7 lock rises, flag not yet", rd_data, 8'h08);
    step();
    chk("R7 rising lock change", rd_data, 8'h18);
    lock_irq_en = 1'b1; #1;
    chk("R4 lock irq", {7'd0, lock_irq}, 8'h01);
    wr(8'h10);
    chk("R7 change flag cleared", rd_data, 8'h08);
    pll_lock = 1'b0; step();
    chk("R7 lock falls", rd_data, 8'h00);
    step();
    chk("R7 falling lock change", rd_data, 8'h10);
    wr(8'h10); lock_irq_en = 1'b0;
    pll_track = 1'b1; step();
    chk("R8 track follows", rd_data, 8'h04);
    wr(8'hFF);
    chk("R8 write ignored by status", rd_data, 8'h04);
    pll_track = 1'b0; step();
  endtask

  task automatic t_self_clock();
    pll_lock = 1'b1; pll_track = 1'b1; step(); step();
    wr(8'hFF);
    chk("R8 lock and track live", rd_data, 8'h0C);
    self_clk = 1'b1; step();
    chk("R9 gated in self-clock", rd_data, 8'h01);
    step();
    chk("R1 full byte layout", rd_data, 8'h13);
    scm_irq_en = 1'b1; #1;
    chk("R4 scm irq", {7'd0, scm_irq}, 8'h01);
    wr(8'h12); scm_irq_en = 1'b0;
    self_clk = 1'b0; step();
    chk("R9 leaving self-clock", rd_data, 8'h0C);
    step();
    chk("R9 falling scm change", rd_data, 8'h1E);
    pll_lock = 1'b0; pll_track = 1'b0; step(); step();
    wr(8'hFF);
  endtask

  task automatic t_domains();
    lowv_rst_evt = 1'b1; step(); lowv_rst_evt = 1'b0;
    pwr_on_rst = 1'b1; step(); pwr_on_rst = 1'b0;
    chk("R6 power-on clears low-voltage flag", rd_data, 8'h40);
    lowv_rst_evt = 1'b1; step(); lowv_rst_evt = 1'b0;
    tmo_pulse = 1'b1; step(); tmo_pulse = 1'b0;
    chk("R6 low-voltage flag sets", rd_data, 8'hE0);
    sys_rst = 1'b1; step(); step(); sys_rst = 1'b0;
    chk("R5 R6 flags survive system reset", rd_data, 8'h60);
    wr(8'h20);
    chk("R6 write 1 clears", rd_data, 8'h40);
    wr(8'h40);
    chk("R5 write 1 clears", rd_data, 8'h00);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_timeout();
    t_set_wins();
    t_lock();
    t_self_clock();
    t_domains();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule